// File: doc/BRIEF.md
# Zero-Count Unidirectional Error Code Unit

This block guards a data path against unidirectional corruption, where every flipped bit in a word moves in the same direction (all ones decaying to zeros, or all zeros rising to ones). It has two independent halves that share one clock.

The encoding half takes an information word and appends a check field. That field holds the binary number of zero bits in the word. The checking half takes a received information word and a received check field. It counts the zeros again, compares the count with the field, and reports the result on a pair of complementary rails.

Both halves register their results, so each output appears one cycle after its valid input. The rails avoid a single error wire, because a single wire stuck at its "good" level would never be noticed. In the error-free case the rail pair alternates between its two good patterns on every valid check. This means a rail stuck at one value shows up as an error within two checks.

Top module: `zcount_codec`

## Requirements
- R1: The check field is the count of zero bits in the information word, with width ceil(log2(DATA_W+1)); with the default DATA_W=8 it is 4 bits, so 8'h00 gives 8, 8'hFF gives 0 and 8'hA5 gives 4.
- R2: The codeword places the information word in the upper DATA_W bits and the check field in the lower bits. `enc_vld_o` and `enc_word_o` follow `enc_vld_i` by exactly one cycle, and `enc_word_o` holds its value in cycles with no valid input.
- R3: When the recomputed zero count equals `chk_field_i`, the rails registered one cycle later are complementary (01 or 10), and `chk_vld_o` is 1.
- R4: When the recomputed zero count differs from `chk_field_i`, the rails registered one cycle later are equal (00 or 11).
- R5: Bit 1 of the rail pair inverts on every valid check. The first valid check after reset gives bit 1 = 0, so a clean result reads 01, then 10, then 01, and so on. An error result reads 00 when bit 1 is 0 and 11 when bit 1 is 1.
- R6: Synchronous active-high reset sets `enc_vld_o`=0, `enc_word_o`=0, `chk_vld_o`=0 and rails=10, and restarts the alternation of R5.
- R7: In a cycle without `chk_vld_i`, the rails and the alternation phase do not change, and `chk_vld_o` is 0.
- R8: Every unidirectional error in a codeword is flagged. This covers any nonzero set of 1→0 flips, or any nonzero set of 0→1 flips, spread across the information and check bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_vld_i | input | 1 | Information word to encode is valid |
| enc_data_i | input | DATA_W | Information word to encode |
| enc_vld_o | output | 1 | Codeword output valid |
| enc_word_o | output | DATA_W+CHK_W | Codeword: {information, zero count} |
| chk_vld_i | input | 1 | Received word and check field are valid |
| chk_data_i | input | DATA_W | Received information word |
| chk_field_i | input | CHK_W | Received check field |
| chk_vld_o | output | 1 | Rail result valid |
| chk_rail_o | output | 2 | Dual-rail result: 01/10 clean, 00/11 error |

## Verification
The hardest condition to reach from the ports is a unidirectional corruption that spans both the information bits and the check field. In that case the count moves one way and the stored field moves the other. The stimulus takes a clean codeword and walks every nonzero subset of its one bits cleared together. It then walks every nonzero subset of its zero bits set together. Each corrupted word goes through the checker on consecutive valid cycles, so the alternating rail phase is tested at the same time against both error patterns.

// File: rtl/zc_pkg.sv
package zc_pkg;

  // Width of a field able to hold any count from 0 to k
  function automatic int chk_width(input int k);
    return $clog2(k + 1);
  endfunction

  // Rail value presented after reset and before any check
  localparam logic [1:0] RAIL_RESET = 2'b10;

endpackage

// File: rtl/zc_zero_count.sv
module zc_zero_count #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = zc_pkg::chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  zeros_o
);

  logic [CHK_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < DATA_W; i++) begin
      acc = acc + CHK_W'(~data_i[i]);
    end
  end

  assign zeros_o = acc;

  always_comb begin
    AST_COUNT_RANGE: assert (int'(zeros_o) <= DATA_W); // R1
  end

endmodule

// File: rtl/zc_encoder.sv
module zc_encoder #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = zc_pkg::chk_width(DATA_W),
  localparam int WORD_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);

  logic [CHK_W-1:0] zeros_w;

  zc_zero_count #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_cnt (
    .data_i  (data_i),
    .zeros_o (zeros_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      word_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) word_o <= {data_i, zeros_w};
    end
  end

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o); // R2
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> ($stable(word_o) && !vld_o)); // R2

endmodule

// File: rtl/zc_checker.sv
module zc_checker #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = zc_pkg::chk_width(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  field_i,
  output logic              vld_o,
  output logic [1:0]        rail_o
);

  logic [CHK_W-1:0] zeros_w;
  logic             phase_q;
  logic             differ;

  zc_zero_count #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_cnt (
    .data_i  (data_i),
    .zeros_o (zeros_w)
  );

  assign differ = (zeros_w != field_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      vld_o   <= 1'b0;
      rail_o  <= zc_pkg::RAIL_RESET;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        rail_o  <= differ ? {phase_q, phase_q} : {phase_q, ~phase_q};
        phase_q <= ~phase_q;
      end
    end
  end

  AST_CLEAN_RAILS: assert property (@(posedge clk) disable iff (rst)
    (vld_i && zeros_w == field_i) |=> (vld_o && (rail_o[1] ^ rail_o[0]))); // R3
  AST_BAD_RAILS: assert property (@(posedge clk) disable iff (rst)
    (vld_i && zeros_w != field_i) |=> (rail_o[1] == rail_o[0])); // R4
  AST_RAIL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (rail_o[1] != $past(rail_o[1]))); // R5
  AST_RAIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> ($stable(rail_o) && !vld_o)); // R7

endmodule

// File: rtl/zcount_codec.sv
module zcount_codec #(
  parameter int DATA_W = 8,
  localparam int CHK_W  = zc_pkg::chk_width(DATA_W),
  localparam int WORD_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_vld_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_vld_o,
  output logic [WORD_W-1:0] enc_word_o,
  input  logic              chk_vld_i,
  input  logic [DATA_W-1:0] chk_data_i,
  input  logic [CHK_W-1:0]  chk_field_i,
  output logic              chk_vld_o,
  output logic [1:0]        chk_rail_o
);

  zc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (enc_vld_i),
    .data_i (enc_data_i),
    .vld_o  (enc_vld_o),
    .word_o (enc_word_o)
  );

  zc_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .vld_i   (chk_vld_i),
    .data_i  (chk_data_i),
    .field_i (chk_field_i),
    .vld_o   (chk_vld_o),
    .rail_o  (chk_rail_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!enc_vld_o && !chk_vld_o && chk_rail_o == 2'b10 && enc_word_o == '0)); // R6

endmodule

// File: tb/tb_zcount_codec.sv
module tb_zcount_codec;

  localparam int DW = 8;
  localparam int CW = 4;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enc_vld_i = 1'b0;
  logic [DW-1:0] enc_data_i = '0;
  logic          enc_vld_o;
  logic [DW+CW-1:0] enc_word_o;
  logic          chk_vld_i = 1'b0;
  logic [DW-1:0] chk_data_i = '0;
  logic [CW-1:0] chk_field_i = '0;
  logic          chk_vld_o;
  logic [1:0]    chk_rail_o;

  int total = 0;
  int bad   = 0;
  bit ph    = 1'b0;

  always #4 clk = ~clk;

  zcount_codec #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .enc_vld_i(enc_vld_i), .enc_data_i(enc_data_i),
    .enc_vld_o(enc_vld_o), .enc_word_o(enc_word_o),
    .chk_vld_i(chk_vld_i), .chk_data_i(chk_data_i), .chk_field_i(chk_field_i),
    .chk_vld_o(chk_vld_o), .chk_rail_o(chk_rail_o)
  );

  // {data, field, expect_error}
  localparam logic [DW+CW:0] VEC [NV] = '{
    {8'h00, 4'd8, 1'b0},
    {8'hFF, 4'd0, 1'b0},
    {8'hA5, 4'd4, 1'b0},
    {8'hA5, 4'd5, 1'b1},
    {8'h0F, 4'd4, 1'b0},
    {8'h01, 4'd7, 1'b0},
    {8'h80, 4'd6, 1'b1},
    {8'hFE, 4'd1, 1'b0},
    {8'hFF, 4'd15, 1'b1},
    {8'h3C, 4'd0, 1'b1}
  };

  function automatic logic [CW-1:0] ref_zeros(input logic [DW-1:0] d);
    logic [CW-1:0] n = '0;
    for (int i = 0; i < DW; i++) if (d[i] == 1'b0) n = n + 1'b1;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected rail pair for one valid check; advances the bench phase (R5)
  function automatic logic [1:0] next_rail(input bit err);
    logic [1:0] r = err ? {ph, ph} : {ph, ~ph};
    ph = ~ph;
    return r;
  endfunction

  task automatic do_check(input logic [DW-1:0] d, input logic [CW-1:0] f, input bit err, input string req);
    logic [1:0] er;
    @(negedge clk);
    chk_vld_i = 1'b1; chk_data_i = d; chk_field_i = f;
    @(posedge clk); #1;
    chk_vld_i = 1'b0;
    er = next_rail(err);
    check(chk_vld_o === 1'b1 && chk_rail_o === er, req, {chk_vld_o, chk_rail_o}, {1'b1, er});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    ph = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] cw;
    logic [11:0] cm;
    logic [1:0]  held;
    repeat (2) @(posedge clk); #1;
    // R6 reset state
    check(enc_vld_o === 1'b0 && chk_vld_o === 1'b0, "R6 valids", {enc_vld_o, chk_vld_o}, 0);
    check(chk_rail_o === 2'b10 && enc_word_o === '0, "R6 rails/word", {chk_rail_o, enc_word_o}, {2'b10, 12'h0});
    @(negedge clk); rst = 1'b0;

    // Vector walk: encode and check in the same cycle
    for (int v = 0; v < NV; v++) begin
      logic [DW-1:0] d;
      logic [CW-1:0] f;
      logic [1:0]    er;
      bit            e;
      {d, f, e} = VEC[v];
      @(negedge clk);
      enc_vld_i = 1'b1; enc_data_i = d;
      chk_vld_i = 1'b1; chk_data_i = d; chk_field_i = f;
      @(posedge clk); #1;
      er = next_rail(e);
      check(enc_vld_o === 1'b1 && enc_word_o === {d, ref_zeros(d)}, "R1 R2 codeword",
            enc_word_o, {d, ref_zeros(d)});
      check(chk_vld_o === 1'b1 && chk_rail_o === er, e ? "R4 R5 error rails" : "R3 R5 clean rails",
            chk_rail_o, er);
    end

    // R2 R7 idle cycles hold everything
    @(negedge clk);
    enc_vld_i = 1'b0; chk_vld_i = 1'b0;
    enc_data_i = 8'h5A; chk_data_i = 8'h5A; chk_field_i = 4'd0;
    held = chk_rail_o;
    cw = enc_word_o;
    repeat (3) @(posedge clk); #1;
    check(enc_vld_o === 1'b0 && enc_word_o === cw, "R2 word hold", enc_word_o, cw);
    check(chk_vld_o === 1'b0 && chk_rail_o === held, "R7 rail hold", chk_rail_o, held);
    // phase not advanced by idle: next clean continues the sequence
    do_check(8'h5A, 4'd4, 1'b0, "R7 R5 phase after idle");

    // R8 unidirectional errors on codeword {F8, 3}: all 1->0 subsets then all 0->1 subsets
    cw = {8'hF8, 4'd3};
    for (int m = 1; m < 4096; m++) begin
      cm = 12'(m);
      if ((cm & ~cw) == 12'h0) begin
        logic [11:0] bad_w = cw & ~cm;
        do_check(bad_w[11:4], bad_w[3:0], 1'b1, "R8 falling");
      end else if ((cm & cw) == 12'h0) begin
        logic [11:0] bad_w = cw | cm;
        do_check(bad_w[11:4], bad_w[3:0], 1'b1, "R8 rising");
      end
    end

    // R6 mid-stream reset restarts alternation
    do_reset();
    #1;
    check(chk_rail_o === 2'b10 && chk_vld_o === 1'b0, "R6 reset mid-run", chk_rail_o, 2'b10);
    do_check(8'hFF, 4'd0, 1'b0, "R6 R5 first after reset 01");
    do_check(8'hFF, 4'd0, 1'b0, "R5 second clean 10");
    do_check(8'h00, 4'd0, 1'b1, "R4 R5 error 00");
    do_check(8'h00, 4'd0, 1'b1, "R4 R5 error 11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule